// File: doc/BRIEF.md
# Command set allocator with in-flight conflict check

This block hands out command sets to requesters on behalf of one voter. The sets are grouped by type: sleep, wake and active. Each type owns a contiguous run of set indices, laid out in that type order. The control type owns no index. A requester presents up to sixteen resource addresses. The block accepts the request only when none of those addresses is pending in a set of the active group that is still busy. If the request passes that check, the block hands back the lowest-numbered free set of the active group and marks that set as taken in the same cycle.

The in-flight check walks the active group one slot per clock. A slot takes part only when its enable bit is set and its set is not free. A set counts as free when its in-use bit is clear and its hardware idle flag is high. The result comes out as a one-cycle done strobe carrying exactly one of three flags: grant, busy or invalid. A busy result covers both an address conflict and the case where no set is free. Requests that are malformed, or that are not of the active type, are turned away as invalid and take no scan at all.

Each serviced completion names one set. In response the block releases that set's in-use bit and pulses two one-hot strobes: one zeroes the set's enable mask and one acknowledges its interrupt. The interrupt-enable output covers the active group only.

Top module: `cmdset_alloc`

## Requirements
- R1: A request whose type code is not active (type encoding: 0 sleep, 1 wake, 2 active, 3 control) gets done with invalid at the clock edge that accepts it, and no in-use bit changes.
- R2: A request with a count of 0, or with a count above MAXREQ (16), gets done with invalid at the accepting edge. A count of exactly 16 is valid.
- R3: A valid request gets busy and allocates nothing when any of its first count addresses equals the address of an enabled slot in a non-free set of the active group. Addresses at positions at or beyond count, disabled slots, and slots of free sets never cause busy.
- R4: A set is free only when its in-use bit is clear and its set_idle bit is high. A set that is not idle is never granted.
- R5: A grant names the lowest-indexed free set of the active group by absolute index, the active group starting at N_SLEEP+N_WAKE. Its in_use bit goes high at the same edge as done.
- R6: A conflict-free valid request gets busy when the active group has no free set.
- R7: A valid request's done arrives N_ACTIVE*SLOTS clock edges after the accepting edge. Done lasts one cycle and carries exactly one of grant, busy or invalid. Those flags are low when done is low.
- R8: cmpl_valid with cmpl_set clears that in_use bit at the next edge. At that same edge en_clr and irq_clr pulse one-hot on that set for one cycle.
- R9: irq_en is high exactly for the indices of the active group.
- R10: req_valid is ignored while a scan is running. That request yields no done, and the running request's result is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New request present |
| req_type | input | 2 | Request type code |
| req_count | input | 5 | Number of addresses in the request |
| req_addr | input | MAXREQ*AW (256) | Request addresses, entry k at bits k*AW |
| set_idle | input | NSETS (6) | Hardware idle flag per set |
| slot_en | input | NSETS*SLOTS (96) | Slot enable per set, slot j of set s at bit s*SLOTS+j |
| slot_addr | input | NSETS*SLOTS*AW (1536) | Slot addresses, same order as slot_en |
| cmpl_valid | input | 1 | Completion serviced |
| cmpl_set | input | SW (3) | Set whose completion is serviced |
| done | output | 1 | Result strobe |
| grant | output | 1 | Request granted |
| busy | output | 1 | Request refused: conflict or no free set |
| invalid | output | 1 | Request malformed or wrong type |
| grant_set | output | SW (3) | Granted set index |
| in_use | output | NSETS (6) | Allocation bits |
| en_clr | output | NSETS (6) | Enable-mask clear strobe |
| irq_clr | output | NSETS (6) | Interrupt acknowledge strobe |
| irq_en | output | NSETS (6) | Interrupt enable mask |

## Verification
An invalid result is registered at the very edge that accepts the request. A valid request's result lands N_ACTIVE*SLOTS edges later, which is 32 with the defaults. Completion strobes and the in-use release appear at the edge that samples cmpl_valid. The bench drives and samples on falling edges. After each request it counts falling edges from the accepting edge and compares the index of the first done against 0 or 32. It also watches a few cycles beyond that point for stray strobes.

// File: rtl/cmdset_alloc.sv
module cmdset_alloc #(
  parameter int N_SLEEP = 2,
  parameter int N_WAKE = 2,
  parameter int N_ACTIVE = 2,
  parameter int SLOTS = 16,
  parameter int MAXREQ = 16,
  parameter int AW = 16,
  localparam int NSETS = N_SLEEP + N_WAKE + N_ACTIVE,
  localparam int SW = (NSETS > 1) ? $clog2(NSETS) : 1,
  localparam int CW = $clog2(MAXREQ) + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic [1:0]                  req_type,
  input  logic [CW-1:0]               req_count,
  input  logic [MAXREQ*AW-1:0]        req_addr,
  input  logic [NSETS-1:0]            set_idle,
  input  logic [NSETS*SLOTS-1:0]      slot_en,
  input  logic [NSETS*SLOTS*AW-1:0]   slot_addr,
  input  logic                        cmpl_valid,
  input  logic [SW-1:0]               cmpl_set,
  output logic                        done,
  output logic                        grant,
  output logic                        busy,
  output logic                        invalid,
  output logic [SW-1:0]               grant_set,
  output logic [NSETS-1:0]            in_use,
  output logic [NSETS-1:0]            en_clr,
  output logic [NSETS-1:0]            irq_clr,
  output logic [NSETS-1:0]            irq_en
);
  localparam int ACT_OFF = N_SLEEP + N_WAKE;
  localparam int ASW = (N_ACTIVE > 1) ? $clog2(N_ACTIVE) : 1;
  localparam int SLW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [1:0] TYPE_ACTIVE = 2'd2;
  localparam logic [NSETS-1:0] ACT_MASK = NSETS'(((1 << N_ACTIVE) - 1) << ACT_OFF);

  logic              scanning, hit, slot_hit, pick_ok, last, req_bad;
  logic [CW-1:0]     cnt_q;
  logic [AW-1:0]     addr_q [MAXREQ];
  logic [ASW-1:0]    set_i;
  logic [SLW-1:0]    slot_i;
  logic [SW-1:0]     pick;
  logic [NSETS-1:0]  avail;

  assign irq_en  = ACT_MASK;
  assign avail   = ~in_use & set_idle;
  assign last    = (set_i == ASW'(N_ACTIVE - 1)) && (slot_i == SLW'(SLOTS - 1));
  assign req_bad = (req_type != TYPE_ACTIVE) || (req_count == '0) || (req_count > CW'(MAXREQ));

  always_comb begin
    int s, ix;
    s = ACT_OFF + int'(set_i);
    ix = s * SLOTS + int'(slot_i);
    slot_hit = 1'b0;
    if (!avail[s] && slot_en[ix])
      for (int k = 0; k < MAXREQ; k++)
        if (CW'(k) < cnt_q && addr_q[k] == slot_addr[ix*AW +: AW]) slot_hit = 1'b1;
  end

  always_comb begin
    pick_ok = 1'b0;
    pick = '0;
    for (int i = N_ACTIVE - 1; i >= 0; i--)
      if (avail[ACT_OFF + i]) begin
        pick_ok = 1'b1;
        pick = SW'(ACT_OFF + i);
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scanning <= 1'b0;
      hit <= 1'b0;
      cnt_q <= '0;
      set_i <= '0;
      slot_i <= '0;
      done <= 1'b0;
      grant <= 1'b0;
      busy <= 1'b0;
      invalid <= 1'b0;
      grant_set <= '0;
      in_use <= '0;
      en_clr <= '0;
      irq_clr <= '0;
      for (int k = 0; k < MAXREQ; k++) addr_q[k] <= '0;
    end else begin
      done <= 1'b0;
      grant <= 1'b0;
      busy <= 1'b0;
      invalid <= 1'b0;
      en_clr <= '0;
      irq_clr <= '0;
      if (cmpl_valid) begin
        in_use[cmpl_set] <= 1'b0;
        en_clr <= NSETS'(1) << cmpl_set;
        irq_clr <= NSETS'(1) << cmpl_set;
      end
      if (!scanning) begin
        if (req_valid) begin
          if (req_bad) begin
            done <= 1'b1;
            invalid <= 1'b1;
          end else begin
            scanning <= 1'b1;
            hit <= 1'b0;
            cnt_q <= req_count;
            set_i <= '0;
            slot_i <= '0;
            for (int k = 0; k < MAXREQ; k++) addr_q[k] <= req_addr[k*AW +: AW];
          end
        end
      end else if (last) begin
        scanning <= 1'b0;
        done <= 1'b1;
        if (hit || slot_hit || !pick_ok) busy <= 1'b1;
        else begin
          grant <= 1'b1;
          grant_set <= pick;
          in_use[pick] <= 1'b1;
        end
      end else begin
        hit <= hit | slot_hit;
        if (slot_i == SLW'(SLOTS - 1)) begin
          slot_i <= '0;
          set_i <= set_i + 1'b1;
        end else slot_i <= slot_i + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cmdset_alloc_chk.sv
module cmdset_alloc_chk #(
  parameter int NSETS = 6,
  parameter int SW = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             cmpl_valid,
  input logic             done,
  input logic             grant,
  input logic             busy,
  input logic             invalid,
  input logic [SW-1:0]    grant_set,
  input logic [NSETS-1:0] in_use,
  input logic [NSETS-1:0] irq_clr
);
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n) done |-> $countones({grant, busy, invalid}) == 1); // R7
  AST_NO_STRAY: assert property (@(posedge clk) disable iff (!rst_n) !done |-> !(grant || busy || invalid)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
  AST_GRANT_MARKS: assert property (@(posedge clk) disable iff (!rst_n) grant |-> in_use[grant_set]); // R5
  AST_GRANT_WAS_FREE: assert property (@(posedge clk) disable iff (!rst_n) grant |-> ($past(in_use) & (NSETS'(1) << grant_set)) == '0); // R4
  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(irq_clr)); // R8
  AST_CLR_AFTER_CMPL: assert property (@(posedge clk) disable iff (!rst_n) cmpl_valid |=> $countones(irq_clr) == 1); // R8
  AST_INVALID_NOW: assert property (@(posedge clk) disable iff (!rst_n) invalid |-> $past(req_valid)); // R1
endmodule

bind cmdset_alloc cmdset_alloc_chk #(.NSETS(NSETS), .SW(SW)) u_chk (.*);

// File: tb/test_cmdset_alloc.sv
module test_cmdset_alloc;
  localparam int CLK_P = 10;
  localparam int N_SLEEP = 2, N_WAKE = 2, N_ACTIVE = 2, SLOTS = 16, MAXREQ = 16, AW = 16;
  localparam int NSETS = N_SLEEP + N_WAKE + N_ACTIVE;
  localparam int SW = 3;
  localparam int ACT_OFF = N_SLEEP + N_WAKE;
  localparam int SCAN_N = N_ACTIVE * SLOTS;

  logic clk = 0, rst_n = 0, req_valid = 0, cmpl_valid = 0;
  logic [1:0] req_type = 0;
  logic [4:0] req_count = 0;
  logic [MAXREQ*AW-1:0] req_addr = '0;
  logic [NSETS-1:0] set_idle = '1;
  logic [NSETS*SLOTS-1:0] slot_en = '0;
  logic [NSETS*SLOTS*AW-1:0] slot_addr = '0;
  logic [SW-1:0] cmpl_set = 0;
  logic done, grant, busy, invalid;
  logic [SW-1:0] grant_set;
  logic [NSETS-1:0] in_use, en_clr, irq_clr, irq_en;
  logic [NSETS-1:0] m_use = '0;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  cmdset_alloc #(.N_SLEEP(N_SLEEP), .N_WAKE(N_WAKE), .N_ACTIVE(N_ACTIVE), .SLOTS(SLOTS),
                 .MAXREQ(MAXREQ), .AW(AW)) i_cmdset_alloc (.*);

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic int predict(output int gs);
    logic [NSETS-1:0] fr;
    fr = ~m_use & set_idle;
    gs = 0;
    if (req_type != 2'd2 || req_count == 0 || req_count > MAXREQ) return 0;
    for (int s = ACT_OFF; s < NSETS; s++)
      if (!fr[s])
        for (int j = 0; j < SLOTS; j++)
          if (slot_en[s*SLOTS+j])
            for (int k = 0; k < int'(req_count); k++)
              if (req_addr[k*AW +: AW] == slot_addr[(s*SLOTS+j)*AW +: AW]) return 1;
    for (int s = ACT_OFF; s < NSETS; s++)
      if (fr[s]) begin gs = s; return 2; end
    return 1;
  endfunction

  task automatic run_req(input logic [1:0] t, input int cnt, input string rq, input bit poke);
    int er, eg, k0, extra, r, g;
    @(negedge clk);
    req_type = t;
    req_count = 5'(cnt);
    er = predict(eg);
    req_valid = 1;
    @(negedge clk);
    k0 = -1; extra = 0; r = -1; g = 0;
    for (int k = 0; k < SCAN_N + 4; k++) begin
      if (k > 0) @(negedge clk);
      if (done) begin
        if (k0 < 0) begin
          k0 = k;
          r = invalid ? 0 : (busy ? 1 : (grant ? 2 : -1));
          g = int'(grant_set);
        end else extra++;
      end
      if (poke && k == 3) begin req_valid = 1; req_type = 2'd0; end
      else req_valid = 0;
    end
    if (er == 2) m_use[eg] = 1'b1;
    chk(k0 == ((er == 0) ? 0 : SCAN_N), "R7", "done latency", k0, (er == 0) ? 0 : SCAN_N);
    chk(r == er, rq, "result kind", r, er);
    if (er == 2) chk(g == eg, "R5", "grant_set", g, eg);
    chk(in_use == m_use, (er == 2) ? "R5" : rq, "in_use", int'(in_use), int'(m_use));
    chk(extra == 0, poke ? "R10" : "R7", "extra done", extra, 0);
  endtask

  task automatic complete(input int s);
    @(negedge clk);
    cmpl_valid = 1; cmpl_set = SW'(s);
    @(negedge clk);
    cmpl_valid = 0;
    m_use[s] = 1'b0;
    chk(irq_clr == NSETS'(1) << s, "R8", "irq_clr", int'(irq_clr), 1 << s);
    chk(en_clr == NSETS'(1) << s, "R8", "en_clr", int'(en_clr), 1 << s);
    chk(in_use == m_use, "R8", "in_use release", int'(in_use), int'(m_use));
    @(negedge clk);
    chk(irq_clr == 0 && en_clr == 0, "R8", "strobe width", int'(irq_clr | en_clr), 0);
  endtask

  task automatic put_slot(input int s, input int j, input bit en, input int a);
    slot_en[s*SLOTS+j] = en;
    slot_addr[(s*SLOTS+j)*AW +: AW] = AW'(a);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [NSETS-1:0] exp_mask;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    exp_mask = '0;
    for (int i = 0; i < N_ACTIVE; i++) exp_mask[ACT_OFF+i] = 1'b1;
    chk(done == 0 && in_use == 0, "R7", "reset state", int'({done, in_use}), 0);
    chk(irq_en == exp_mask, "R9", "irq_en", int'(irq_en), int'(exp_mask));

    req_addr[0 +: AW] = 16'h1234;
    run_req(2'd2, 1, "R5", 0);
    run_req(2'd2, 1, "R5", 0);
    run_req(2'd2, 1, "R6", 0);
    complete(ACT_OFF);
    put_slot(ACT_OFF+1, 3, 1, 16'h1234);
    run_req(2'd2, 1, "R3", 0);
    req_addr[0 +: AW] = 16'h0001; req_addr[AW +: AW] = 16'h0002; req_addr[2*AW +: AW] = 16'h1234;
    run_req(2'd2, 2, "R3", 0);
    complete(ACT_OFF);
    put_slot(ACT_OFF+1, 3, 0, 16'h0001);
    run_req(2'd2, 1, "R3", 0);
    complete(ACT_OFF);
    set_idle[ACT_OFF] = 0;
    run_req(2'd2, 1, "R4", 0);
    set_idle[ACT_OFF] = 1;
    complete(ACT_OFF + 1);
    put_slot(ACT_OFF, 0, 1, 16'h0001);
    run_req(2'd2, 1, "R3", 0);
    complete(ACT_OFF);
    run_req(2'd0, 1, "R1", 0);
    run_req(2'd1, 1, "R1", 0);
    run_req(2'd3, 1, "R1", 0);
    run_req(2'd2, 0, "R2", 0);
    run_req(2'd2, 17, "R2", 0);
    run_req(2'd2, 16, "R2", 0);
    run_req(2'd2, 1, "R10", 1);
    complete(ACT_OFF);
    complete(ACT_OFF + 1);

    for (int it = 0; it < 300; it++) begin
      int cnt, p;
      logic [1:0] t;
      if (m_use != 0 && ($urandom % 2) == 0) begin
        int s = ACT_OFF + int'($urandom % N_ACTIVE);
        if (m_use[s]) complete(s);
      end
      for (int s = 0; s < NSETS; s++) begin
        set_idle[s] = ($urandom % 8) != 0;
        for (int j = 0; j < SLOTS; j++) put_slot(s, j, ($urandom % 4) == 0, int'($urandom % 8));
      end
      for (int k = 0; k < MAXREQ; k++) req_addr[k*AW +: AW] = AW'($urandom % 24);
      p = int'($urandom % 10);
      t = (p == 0) ? 2'($urandom % 2) : ((p == 1) ? 2'd3 : 2'd2);
      p = int'($urandom % 12);
      cnt = (p == 0) ? 0 : ((p == 1) ? 17 + int'($urandom % 15) : 1 + int'($urandom % 3));
      run_req(t, cnt, (t != 2'd2) ? "R1" : ((cnt == 0 || cnt > MAXREQ) ? "R2" : "R3"), 0);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule